// File: doc/BRIEF.md
# Serial flash command framer

This block is the host-side front end that opens a command to a page-organised serial flash device over a four-wire serial bus. A request strobe presents an 8-bit opcode, an 11-bit page number, a 9-bit byte offset, a page-size mode select and a hold flag. The block pulls chip select low and shifts a 32-bit header onto the data line. The header is the opcode followed by a 24-bit packed address, and every bit goes most significant first.

The address packing depends on the mode. With 264-byte pages, the 9-bit offset sits under the page number. With 256-byte binary pages, only the low 8 offset bits are used and the page number sits directly above them. The serial clock runs in mode 0 and is derived from the system clock by a parameterised divider.

When the header is complete the block pulses `done`. It then either releases chip select or keeps it low so that a later data phase can follow.

Top module: `sflash_cmd_framer`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `mosi` is 0, `busy` is 0 and `done` is 0.
- R2: A request accepted while idle drives `cs_n` low and produces exactly 32 rising `sck` edges before `done`. The bits sampled on those edges are `opcode[7:0]` followed by the 24-bit address, both most significant bit first.
- R3: `sck` is low whenever `cs_n` is high. `mosi` changes only while `sck` is low. Each high and low phase of `sck` lasts `CLK_DIV` system clocks.
- R4: With `bin_mode`=0 the address is `{4'b0, page[10:0], offset[8:0]}`, so page 2047 with offset 263 gives 24'h0FFF07.
- R5: With `bin_mode`=1 the address is `{5'b0, page[10:0], offset[7:0]}`. `offset[8]` is ignored, so page 2047 with offset 9'h1FF gives 24'h07FFFF.
- R6: `busy` is 1 from the cycle after an accepted request until `done`. `done` is a single-cycle pulse, due `CLK_DIV` cycles after the last falling `sck` edge, and `busy` is 0 in that cycle.
- R7: With `hold_cs`=0 at the request, `cs_n` is 1 in the cycle that `done` is 1.
- R8: With `hold_cs`=1 at the request, `cs_n` stays 0 after `done` until a `cs_release` pulse, and is 1 in the following cycle. Requests made while chip select is held this way are ignored.
- R9: A request made while `busy` is 1 is ignored. It starts no header and changes nothing in the header already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Command request strobe |
| opcode | input | 8 | Command opcode |
| page | input | 11 | Page number, 0 to 2047 |
| offset | input | 9 | Byte offset within page |
| bin_mode | input | 1 | 1 selects 256-byte page address packing |
| hold_cs | input | 1 | Keep chip select low after the header |
| cs_release | input | 1 | Releases a held chip select |
| cs_n | output | 1 | Device chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the device |
| busy | output | 1 | Header transfer in progress |
| done | output | 1 | One-cycle pulse when the header is sent |

## Verification
Once a request is accepted, the header takes 64 half-periods of `CLK_DIV` cycles each. `done` follows `CLK_DIV` cycles after the last falling serial clock edge. A released chip select is high one cycle after `cs_release`.

The monitor never waits a fixed delay for the header. It samples on the falling system clock edge and checks each result in the cycle the result is due. The bits come from a device model clocked by rising `sck`. The frame is compared at the `done` pulse, and the gap since the last falling `sck` edge is measured in cycles. Each `sck` high phase is timed against `CLK_DIV`, and chip select is checked in the `done` cycle and one cycle after a release.

// File: rtl/sflash_cmd_framer.sv
module sflash_cmd_framer #(
  parameter int CLK_DIV = 2,
  parameter int OP_W    = 8,
  parameter int PAGE_W  = 11,
  parameter int OFS_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [OP_W-1:0]   opcode,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  offset,
  input  logic              bin_mode,
  input  logic              hold_cs,
  input  logic              cs_release,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done
);
  localparam int ADDR_W  = 24;
  localparam int FRAME_W = OP_W + ADDR_W;
  localparam int BC_W    = $clog2(FRAME_W);
  localparam int DV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TAIL, S_HELD} state_t;

  state_t             state;
  logic [FRAME_W-1:0] frame;
  logic [BC_W-1:0]    bit_cnt;
  logic [DV_W-1:0]    div_cnt;
  logic               hold_q;
  logic               tick;
  logic [ADDR_W-1:0]  addr_std, addr_bin;

  assign addr_std = ADDR_W'({page, offset});
  assign addr_bin = ADDR_W'({page, offset[OFS_W-2:0]});
  assign tick     = (div_cnt == DV_W'(CLK_DIV - 1));
  assign busy     = (state == S_SHIFT) || (state == S_TAIL);
  assign mosi     = !cs_n && frame[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      frame   <= '0;
      bit_cnt <= '0;
      div_cnt <= '0;
      hold_q  <= 1'b0;
      cs_n    <= 1'b1;
      sck     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req) begin
            frame   <= {opcode, bin_mode ? addr_bin : addr_std};
            hold_q  <= hold_cs;
            cs_n    <= 1'b0;
            sck     <= 1'b0;
            bit_cnt <= '0;
            div_cnt <= '0;
            state   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            div_cnt <= '0;
            if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck <= 1'b0;
              if (bit_cnt == BC_W'(FRAME_W - 1)) begin
                state <= S_TAIL;
              end else begin
                frame   <= {frame[FRAME_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        S_TAIL: begin
          if (tick) begin
            div_cnt <= '0;
            done    <= 1'b1;
            if (hold_q) begin
              state <= S_HELD;
            end else begin
              cs_n  <= 1'b1;
              state <= S_IDLE;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        S_HELD: begin
          if (cs_release) begin
            cs_n  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sflash_cmd_framer_chk.sv
module sflash_cmd_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_release,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic busy,
  input logic done
);
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  a_r2_sck_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> busy);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_busy_clear_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_cs_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (done || $past(cs_release)));
endmodule

bind sflash_cmd_framer sflash_cmd_framer_chk u_chk (.*);

// File: tb/sflash_cmd_framer_bench.sv
module sflash_cmd_framer_bench;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  opcode = '0;
  logic [10:0] page = '0;
  logic [8:0]  offset = '0;
  logic        bin_mode = 1'b0;
  logic        hold_cs = 1'b0;
  logic        cs_release = 1'b0;
  logic        cs_n, sck, mosi, busy, done;

  always #2 clk = ~clk;

  sflash_cmd_framer #(.CLK_DIV(DIV)) u_sflash_cmd_framer (
    .clk(clk), .rst_n(rst_n), .req(req), .opcode(opcode), .page(page),
    .offset(offset), .bin_mode(bin_mode), .hold_cs(hold_cs),
    .cs_release(cs_release), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .busy(busy), .done(done));

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [32:0] expq[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(input logic [7:0] op, input logic [10:0] pg,
                                            input logic [8:0] of, input logic bm);
    logic [23:0] a;
    if (bm) a = {5'b0, pg, of[7:0]};
    else    a = {4'b0, pg, of};
    return {op, a};
  endfunction

  // device model: captures on rising sck while selected
  logic [31:0] cap;
  int ncap;
  always @(negedge cs_n) begin
    cap = '0;
    ncap = 0;
  end
  always @(posedge sck) if (!cs_n) begin
    cap = {cap[30:0], mosi};
    ncap++;
  end

  // monitor
  int cyc = 0, last_fall = 0, last_rise = 0;
  logic sck_d = 1'b0;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (!sck_d && sck) last_rise = cyc;
    if (sck_d && !sck) begin
      last_fall = cyc;
      check(cyc - last_rise == DIV, "R3 sck high phase", 64'(cyc - last_rise), 64'(DIV));
    end
    sck_d = sck;
    if (done) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected done", 64'(1), 64'(0));
      end else begin
        logic [32:0] it;
        it = expq.pop_front();
        check(cap == it[31:0], "R2/R4/R5 header bits", 64'(cap), 64'(it[31:0]));
        check(ncap == 32, "R2 rising edge count", 64'(ncap), 64'(32));
        check(cyc - last_fall == DIV, "R6 done timing", 64'(cyc - last_fall), 64'(DIV));
        check(busy == 1'b0, "R6 busy at done", 64'(busy), 64'(0));
        check(cs_n == !it[32], "R7/R8 cs at done", 64'(cs_n), 64'(!it[32]));
      end
    end
  end

  task automatic send(input logic [7:0] op, input logic [10:0] pg, input logic [8:0] of,
                      input logic bm, input logic hd);
    @(negedge clk);
    opcode = op; page = pg; offset = of; bin_mode = bm; hold_cs = hd; req = 1'b1;
    expq.push_back({hd, exp_frame(op, pg, of, bm)});
    @(negedge clk);
    req = 1'b0;
    check(busy == 1'b1, "R6 busy after accept", 64'(busy), 64'(1));
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #40000;
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({cs_n, sck, mosi, busy, done} == 5'b10000, "R1 reset state",
          64'({cs_n, sck, mosi, busy, done}), 64'(5'b10000));
    rst_n = 1'b1;
    @(negedge clk);
    check({cs_n, sck, busy, done} == 4'b1000, "R1 after reset release",
          64'({cs_n, sck, busy, done}), 64'(4'b1000));

    send(8'hD2, 11'd0, 9'd0, 1'b0, 1'b0);             wait_done();
    send(8'h52, 11'd2047, 9'd263, 1'b0, 1'b0);         wait_done();   // R4 max
    send(8'hA5, 11'd2047, 9'h1FF, 1'b1, 1'b0);         wait_done();   // R5 masking
    send(8'h0B, 11'd1234, 9'h155, 1'b1, 1'b0);         wait_done();   // R5
    send(8'h81, 11'd5, 9'h0AA, 1'b0, 1'b0);            wait_done();   // R4

    // R9: request while busy is ignored
    send(8'h3C, 11'd700, 9'd17, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    opcode = 8'hFF; page = 11'h7FF; offset = 9'h1FF; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(busy == 1'b1, "R9 still busy", 64'(busy), 64'(1));
    wait_done();
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && cs_n == 1'b1, "R9 no second header",
          64'({busy, cs_n}), 64'(2'b01));

    // R8: hold chip select
    send(8'h84, 11'd99, 9'd3, 1'b0, 1'b1);
    wait_done();
    repeat (5) @(negedge clk);
    check(cs_n == 1'b0, "R8 cs held low", 64'(cs_n), 64'(0));
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && cs_n == 1'b0 && sck == 1'b0, "R8 request ignored while held",
          64'({busy, cs_n, sck}), 64'(3'b000));
    cs_release = 1'b1;
    @(negedge clk);
    cs_release = 1'b0;
    check(cs_n == 1'b1, "R8 cs released", 64'(cs_n), 64'(1));

    send(8'h1E, 11'd1024, 9'd256, 1'b0, 1'b0);         wait_done();   // after hold
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R9 all headers completed", 64'(expq.size()), 64'(0));
    finish_run();
  end
endmodule